// File: doc/BRIEF.md
# Fast-Link-Pulse Ability Exchange and Mode Resolver

This block runs the pulse-level part of link auto-negotiation on a twisted-pair port. Its transmitter sends a 16-bit ability word, over and over, as a burst of single-cycle pulses. Clock pulses mark fixed positions in the burst. Between each pair of clock pulses is one data slot, where a pulse stands for a 1 and an empty slot stands for a 0.

Its receiver works from the arrival times of the pulses alone. It recovers the word the link partner sends and accepts that word only after the same word has arrived in three bursts in a row. Once it has accepted the word, it raises an acknowledge flag in its own outgoing word.

A resolver then compares the two sets of abilities. It picks the best mode that both sides offer and reports speed and duplex, with no software involved. When the two sides share no mode, it reports that instead.

The block has three sequencers. The transmitter has the states `TX_GAP` (idle time between bursts) and `TX_RUN` (sending the 33 positions). `TX_GAP` goes to `TX_RUN` after `IDLE_CYC` cycles. `TX_RUN` goes back to `TX_GAP` after the last position.

The receiver has the states `RX_HUNT` (waiting for a burst) and `RX_SLOT` (timing one clock interval). Any pulse moves `RX_HUNT` to `RX_SLOT`. `RX_SLOT` returns to `RX_HUNT` in four cases:
- after the 17th clock pulse;
- on a timeout;
- on a pulse that comes too early;
- on a second data pulse in the same slot.

The resolver has the states `RES_WAIT`, `RES_LINK` and `RES_FAIL`:
- `RES_WAIT` goes to `RES_LINK` when a partner word is accepted and a common mode exists.
- `RES_WAIT` goes to `RES_FAIL` when a partner word is accepted and no common mode exists.
- Either result state goes back to `RES_WAIT` when the acceptance is withdrawn.

Top module: `flp_autoneg`

## Requirements
- R1: A burst has 33 positions spaced `SLOT_CYC/2` cycles apart. Each pulse is high for one cycle. Every even position (0, 2, … 32) always carries a pulse, so a burst starts and ends with a clock pulse.
- R2: Odd position 2k+1 carries bit k of the transmitted word, bit 0 first. A pulse means 1 and no pulse means 0.
- R3: The first burst starts `IDLE_CYC` cycles after reset is released. A new burst then starts every 33·`SLOT_CYC/2` + `IDLE_CYC` cycles. The word is captured when a burst starts, and no pulse appears outside a burst.
- R4: A received pulse is taken as data when it arrives between 1/4 and 3/4 of `SLOT_CYC` after the previous clock pulse. It is taken as a clock pulse when it arrives between 3/4 and 5/4 of `SLOT_CYC`. The word is complete after 17 clock pulses, and the recovery tolerates partner spacing anywhere inside these windows.
- R5: If no pulse arrives within 5/4 of `SLOT_CYC`, the burst is discarded. A discarded burst neither adds to nor resets the count of matching bursts.
- R6: `partner_valid` rises after three consecutive complete bursts whose words are equal in every bit except bit 14. `partner_word` then shows the latest accepted word. A word that differs restarts the count at one and clears `partner_valid`.
- R7: Bit 14 of each transmitted word is `local_ability[14]` OR the value of `partner_valid` when that burst started.
- R8: The ability bits sit at fixed positions: bit 5 is 10 half duplex, bit 6 is 10 full duplex, bit 7 is 100 half duplex and bit 8 is 100 full duplex. Bits 4:0 hold the selector. Once a word is accepted, the highest mode both sides set wins, in the order 100 full, 100 half, 10 full, 10 half. `link_resolved` goes high, `speed_100` shows a 100 mode and `full_duplex` shows a full-duplex mode.
- R9: If an accepted word shares no ability bit with the local word, `no_common_mode` goes high. `link_resolved`, `speed_100` and `full_duplex` stay low.
- R10: During reset, every output is low, including `tx_pulse` and `partner_word`.
- R11: When `partner_valid` falls, `link_resolved`, `no_common_mode`, `speed_100` and `full_duplex` clear on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| local_ability | input | 16 | Local ability word to advertise |
| rx_pulse | input | 1 | Received pulse, one cycle per pulse, synchronous to clk |
| tx_pulse | output | 1 | Transmitted pulse |
| partner_valid | output | 1 | Partner word accepted |
| partner_word | output | 16 | Latest accepted partner word |
| link_resolved | output | 1 | A common mode was chosen |
| no_common_mode | output | 1 | Accepted partner word shares no mode with the local word |
| speed_100 | output | 1 | Chosen mode is 100 |
| full_duplex | output | 1 | Chosen mode is full duplex |

## Verification
The partner words cover these patterns:
- sparse words;
- all ones, which puts a pulse in every data slot;
- alternating bits;
- words with each pair of overlapping abilities, so that each of the four priority outcomes and the no-common case is reached once.

Partner bursts are sent at the nominal spacing and also at wider and narrower spacings within the windows, which separates window decoding from exact-match decoding.

Three sequences tell the acceptance rules apart:
- a changed word in the middle of the count;
- a change in the acknowledge bit alone;
- a truncated burst placed between good bursts.

The transmitted pulse train is predicted for every cycle from the burst timing, and the acknowledge slot is checked both before and after acceptance.

// File: rtl/flp_pkg.sv
package flp_pkg;

    localparam int WORD_W   = 16;
    localparam int LAST_POS = 32;
    localparam int BIT_10H  = 5;
    localparam int BIT_100F = 8;
    localparam int BIT_ACK  = 14;

    typedef enum logic [2:0] {
        MODE_NONE,
        MODE_10H,
        MODE_10F,
        MODE_100H,
        MODE_100F
    } mode_e;

    typedef enum logic {
        TX_GAP,
        TX_RUN
    } tx_state_e;

    typedef enum logic {
        RX_HUNT,
        RX_SLOT
    } rx_state_e;

    typedef enum logic [1:0] {
        RES_WAIT,
        RES_LINK,
        RES_FAIL
    } res_state_e;

    // common[3]=100F, [2]=100H, [1]=10F, [0]=10H
    function automatic mode_e pick_mode(input logic [3:0] common);
        if (common[3])      return MODE_100F;
        else if (common[2]) return MODE_100H;
        else if (common[1]) return MODE_10F;
        else if (common[0]) return MODE_10H;
        else                return MODE_NONE;
    endfunction

endpackage

// File: rtl/flp_tx.sv
module flp_tx
    import flp_pkg::*;
#(
    parameter int HALF_CYC = 8,
    parameter int IDLE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    output logic              pulse
);
    localparam int GW = $clog2(IDLE_CYC + 1);
    localparam int CW = $clog2(HALF_CYC + 1);
    localparam int PW = $clog2(LAST_POS + 1);

    tx_state_e         state, state_n;
    logic [GW-1:0]     gap_cnt, gap_n;
    logic [CW-1:0]     cnt, cnt_n;
    logic [PW-1:0]     pos, pos_n;
    logic [WORD_W-1:0] shadow, shadow_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= TX_GAP;
            gap_cnt <= '0;
            cnt     <= '0;
            pos     <= '0;
            shadow  <= '0;
        end else begin
            state   <= state_n;
            gap_cnt <= gap_n;
            cnt     <= cnt_n;
            pos     <= pos_n;
            shadow  <= shadow_n;
        end
    end

    always_comb begin
        state_n  = state;
        gap_n    = gap_cnt;
        cnt_n    = cnt;
        pos_n    = pos;
        shadow_n = shadow;
        unique case (state)
            TX_GAP: begin
                if (gap_cnt == GW'(IDLE_CYC - 1)) begin
                    state_n  = TX_RUN;
                    pos_n    = '0;
                    cnt_n    = '0;
                    shadow_n = word_in;
                end else begin
                    gap_n = gap_cnt + 1'b1;
                end
            end
            TX_RUN: begin
                if (cnt == CW'(HALF_CYC - 1)) begin
                    cnt_n = '0;
                    if (pos == PW'(LAST_POS)) begin
                        state_n = TX_GAP;
                        gap_n   = '0;
                    end else begin
                        pos_n = pos + 1'b1;
                    end
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: state_n = TX_GAP;
        endcase
    end

    // even positions are clocks, odd position 2k+1 carries bit k
    always_comb begin
        pulse = 1'b0;
        if (state == TX_RUN && cnt == '0)
            pulse = !pos[0] || shadow[pos[4:1]];
    end

endmodule

// File: rtl/flp_rx.sv
module flp_rx
    import flp_pkg::*;
#(
    parameter int SLOT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse,
    output logic              word_done,
    output logic [WORD_W-1:0] word_out
);
    localparam int QTR = SLOT_CYC / 4;
    localparam int LIM = 5 * QTR;
    localparam int TW  = $clog2(LIM + 2);
    localparam logic [TW-1:0] T_ONE  = TW'(1);
    localparam logic [TW-1:0] T_QTR  = TW'(QTR);
    localparam logic [TW-1:0] T_3QTR = TW'(3 * QTR);
    localparam logic [TW-1:0] T_LIM  = TW'(LIM);

    rx_state_e         state, state_n;
    logic [TW-1:0]     t, t_n;
    logic [3:0]        bit_idx, bit_n;
    logic              seen, seen_n;
    logic [WORD_W-1:0] word, word_n;
    logic              done, done_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= RX_HUNT;
            t       <= '0;
            bit_idx <= '0;
            seen    <= 1'b0;
            word    <= '0;
            done    <= 1'b0;
        end else begin
            state   <= state_n;
            t       <= t_n;
            bit_idx <= bit_n;
            seen    <= seen_n;
            word    <= word_n;
            done    <= done_n;
        end
    end

    always_comb begin
        state_n = state;
        t_n     = t;
        bit_n   = bit_idx;
        seen_n  = seen;
        word_n  = word;
        done_n  = 1'b0;
        unique case (state)
            RX_HUNT: begin
                if (pulse) begin
                    state_n = RX_SLOT;
                    t_n     = T_ONE;
                    bit_n   = '0;
                    seen_n  = 1'b0;
                end
            end
            RX_SLOT: begin
                if (pulse) begin
                    if (t < T_QTR) begin
                        state_n = RX_HUNT;
                    end else if (t < T_3QTR) begin
                        if (seen) begin
                            state_n = RX_HUNT;
                        end else begin
                            seen_n = 1'b1;
                            t_n    = t + 1'b1;
                        end
                    end else begin
                        word_n[bit_idx] = seen;
                        seen_n          = 1'b0;
                        t_n             = T_ONE;
                        if (bit_idx == 4'd15) begin
                            state_n = RX_HUNT;
                            done_n  = 1'b1;
                        end else begin
                            bit_n = bit_idx + 1'b1;
                        end
                    end
                end else if (t >= T_LIM) begin
                    state_n = RX_HUNT;
                end else begin
                    t_n = t + 1'b1;
                end
            end
            default: state_n = RX_HUNT;
        endcase
    end

    always_comb begin
        word_done = done;
        word_out  = word;
    end

endmodule

// File: rtl/flp_match.sv
module flp_match
    import flp_pkg::*;
#(
    parameter int ACCEPT_CNT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word_in,
    output logic              accepted,
    output logic [WORD_W-1:0] acc_word
);
    localparam int CNW = $clog2(ACCEPT_CNT + 1);
    localparam logic [WORD_W-1:0] CMP_MASK = ~(WORD_W'(1) << BIT_ACK);

    logic [WORD_W-1:0] cand;
    logic [CNW-1:0]    cnt;
    logic              same;

    assign same = (cnt != '0) && (((word_in ^ cand) & CMP_MASK) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand     <= '0;
            cnt      <= '0;
            accepted <= 1'b0;
            acc_word <= '0;
        end else if (word_done) begin
            if (same) begin
                if (cnt < CNW'(ACCEPT_CNT))
                    cnt <= cnt + 1'b1;
                if (cnt >= CNW'(ACCEPT_CNT - 1)) begin
                    accepted <= 1'b1;
                    acc_word <= word_in;
                end
            end else begin
                cand     <= word_in;
                cnt      <= CNW'(1);
                accepted <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/flp_resolve.sv
module flp_resolve
    import flp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accepted,
    input  logic [3:0] loc_modes,
    input  logic [3:0] par_modes,
    output logic       link_resolved,
    output logic       no_common_mode,
    output logic       speed_100,
    output logic       full_duplex
);
    res_state_e state, state_n;
    mode_e      mode, mode_n;
    mode_e      picked;

    assign picked = pick_mode(loc_modes & par_modes);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RES_WAIT;
            mode  <= MODE_NONE;
        end else begin
            state <= state_n;
            mode  <= mode_n;
        end
    end

    always_comb begin
        state_n = state;
        mode_n  = mode;
        unique case (state)
            RES_WAIT: begin
                if (accepted) begin
                    state_n = (picked == MODE_NONE) ? RES_FAIL : RES_LINK;
                    mode_n  = picked;
                end
            end
            RES_LINK, RES_FAIL: begin
                if (!accepted) begin
                    state_n = RES_WAIT;
                    mode_n  = MODE_NONE;
                end
            end
            default: begin
                state_n = RES_WAIT;
                mode_n  = MODE_NONE;
            end
        endcase
    end

    always_comb begin
        link_resolved  = (state == RES_LINK);
        no_common_mode = (state == RES_FAIL);
        speed_100      = link_resolved && (mode == MODE_100F || mode == MODE_100H);
        full_duplex    = link_resolved && (mode == MODE_100F || mode == MODE_10F);
    end

endmodule

// File: rtl/flp_autoneg.sv
module flp_autoneg
    import flp_pkg::*;
#(
    parameter int SLOT_CYC   = 16,
    parameter int IDLE_CYC   = 40,
    parameter int ACCEPT_CNT = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] local_ability,
    input  logic        rx_pulse,
    output logic        tx_pulse,
    output logic        partner_valid,
    output logic [15:0] partner_word,
    output logic        link_resolved,
    output logic        no_common_mode,
    output logic        speed_100,
    output logic        full_duplex
);
    localparam int HALF_CYC = SLOT_CYC / 2;

    logic [WORD_W-1:0] tx_word;
    logic              rx_done;
    logic [WORD_W-1:0] rx_word;

    assign tx_word = local_ability | (WORD_W'(partner_valid) << BIT_ACK);

    flp_tx #(.HALF_CYC(HALF_CYC), .IDLE_CYC(IDLE_CYC)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_in (tx_word),
        .pulse   (tx_pulse)
    );

    flp_rx #(.SLOT_CYC(SLOT_CYC)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse     (rx_pulse),
        .word_done (rx_done),
        .word_out  (rx_word)
    );

    flp_match #(.ACCEPT_CNT(ACCEPT_CNT)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (rx_done),
        .word_in   (rx_word),
        .accepted  (partner_valid),
        .acc_word  (partner_word)
    );

    flp_resolve u_res (
        .clk            (clk),
        .rst_n          (rst_n),
        .accepted       (partner_valid),
        .loc_modes      (local_ability[BIT_100F:BIT_10H]),
        .par_modes      (partner_word[BIT_100F:BIT_10H]),
        .link_resolved  (link_resolved),
        .no_common_mode (no_common_mode),
        .speed_100      (speed_100),
        .full_duplex    (full_duplex)
    );

endmodule

// File: rtl/flp_autoneg_chk.sv
module flp_autoneg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_pulse,
    input logic       partner_valid,
    input logic       link_resolved,
    input logic       no_common_mode,
    input logic       speed_100,
    input logic       full_duplex,
    input logic [1:0] loc_hi,
    input logic [1:0] par_hi
);
    // R1
    tx_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pulse |=> !tx_pulse);

    // R9
    result_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_resolved && no_common_mode));

    // R8
    mode_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 || full_duplex) |-> link_resolved);

    // R11
    drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !partner_valid |=> (!link_resolved && !no_common_mode));

    // R8
    low_speed_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(link_resolved) && !speed_100) |->
            (!$past(loc_hi[0] && par_hi[0]) && !$past(loc_hi[1] && par_hi[1])));

    // R8
    half_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(link_resolved) && speed_100 && !full_duplex) |->
            !$past(loc_hi[1] && par_hi[1]));

endmodule

bind flp_autoneg flp_autoneg_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_pulse       (tx_pulse),
    .partner_valid  (partner_valid),
    .link_resolved  (link_resolved),
    .no_common_mode (no_common_mode),
    .speed_100      (speed_100),
    .full_duplex    (full_duplex),
    .loc_hi         (local_ability[8:7]),
    .par_hi         (partner_word[8:7])
);

// File: tb/flp_autoneg_test.sv
`timescale 1ns/1ps
module flp_autoneg_test;

    localparam int SLOT  = 16;
    localparam int HALF  = SLOT / 2;
    localparam int IDLE  = 40;
    localparam int BURST = 33 * HALF;
    localparam int PER   = BURST + IDLE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] local_ability = 16'h0;
    logic        rx_pulse = 1'b0;
    logic        tx_pulse, partner_valid, link_resolved, no_common_mode;
    logic        speed_100, full_duplex;
    logic [15:0] partner_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    flp_autoneg #(.SLOT_CYC(SLOT), .IDLE_CYC(IDLE), .ACCEPT_CNT(3)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .local_ability  (local_ability),
        .rx_pulse       (rx_pulse),
        .tx_pulse       (tx_pulse),
        .partner_valid  (partner_valid),
        .partner_word   (partner_word),
        .link_resolved  (link_resolved),
        .no_common_mode (no_common_mode),
        .speed_100      (speed_100),
        .full_duplex    (full_duplex)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural prediction of the transmitted pulse train
    int        n = 0;
    logic      exp_tx = 1'b0;
    bit        ack_slot = 0;
    logic      last_ack = 1'b0;
    logic [15:0] shadow = 16'h0;
    string     tag = "R3";

    always @(posedge clk) begin
        if (!rst_n) begin
            n = 0; exp_tx = 1'b0; ack_slot = 0;
        end else begin
            int r, p, b;
            n = n + 1; exp_tx = 1'b0; ack_slot = 0; tag = "R3";
            if (n >= IDLE) begin
                r = (n - IDLE) % PER;
                if (r == 0) shadow = local_ability;
                if (r < BURST && r % HALF == 0) begin
                    p = r / HALF;
                    if (p % 2 == 0) begin
                        exp_tx = 1'b1; tag = "R1";
                    end else begin
                        b = (p - 1) / 2; tag = "R2";
                        if (b == 14) ack_slot = 1;
                        else exp_tx = shadow[b];
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && n > 0) begin
            if (ack_slot) last_ack = tx_pulse;
            else chk(tag, {31'b0, tx_pulse}, {31'b0, exp_tx});
        end
    end

    task automatic do_reset(input logic [15:0] loc);
        @(posedge clk); #1;
        rst_n = 1'b0; rx_pulse = 1'b0; local_ability = loc; last_ack = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", {20'b0, tx_pulse, partner_valid, link_resolved, no_common_mode,
                    speed_100, full_duplex, 6'b0}, 32'h0);
        chk("R10", {16'b0, partner_word}, 32'h0);
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_once();
        rx_pulse = 1'b1; @(negedge clk); rx_pulse = 1'b0;
    endtask

    task automatic send_burst(input logic [15:0] w, input int slot, input int doff, input int nclk);
        for (int k = 0; k < nclk; k++) begin
            pulse_once();
            if (k < 16 && k < nclk - 1) begin
                repeat (doff - 1) @(negedge clk);
                if (w[k]) rx_pulse = 1'b1;
                @(negedge clk); rx_pulse = 1'b0;
                repeat (slot - doff - 1) @(negedge clk);
            end
        end
        repeat (40) @(negedge clk);
    endtask

    task automatic send_n(input logic [15:0] w, input int cnt, input int slot, input int doff);
        for (int i = 0; i < cnt; i++) send_burst(w, slot, doff, 17);
    endtask

    task automatic chk_res(input string req, input logic v, input logic [15:0] w,
                           input logic lk, input logic nc, input logic sp, input logic fd);
        chk(req, {31'b0, partner_valid}, {31'b0, v});
        if (v) chk(req, {16'b0, partner_word}, {16'b0, w});
        chk(req, {28'b0, link_resolved, no_common_mode, speed_100, full_duplex},
                 {28'b0, lk, nc, sp, fd});
    endtask

    initial begin
        // all four abilities, resolves to 100 full
        do_reset(16'h01E1);
        send_burst(16'h01E1, SLOT, HALF, 17);
        chk("R7", {31'b0, last_ack}, 32'h0);
        send_n(16'h01E1, 1, SLOT, HALF);
        chk_res("R6", 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_n(16'h01E1, 1, SLOT, HALF);
        chk_res("R8", 1'b1, 16'h01E1, 1'b1, 1'b0, 1'b1, 1'b1);
        repeat (2 * PER) @(negedge clk);
        chk("R7", {31'b0, last_ack}, 32'h1);

        // 100 half wins over 10 half
        do_reset(16'h00E1);
        send_n(16'h01A1, 3, SLOT, HALF);
        chk_res("R8", 1'b1, 16'h01A1, 1'b1, 1'b0, 1'b1, 1'b0);

        // 10 full, wide partner spacing
        do_reset(16'h0061);
        send_n(16'h0141, 3, 18, 10);
        chk_res("R4", 1'b1, 16'h0141, 1'b1, 1'b0, 1'b0, 1'b1);

        // 10 half, narrow partner spacing
        do_reset(16'h0021);
        send_n(16'h0121, 3, 14, 6);
        chk_res("R4", 1'b1, 16'h0121, 1'b1, 1'b0, 1'b0, 1'b0);

        // nothing in common
        do_reset(16'h0181);
        send_n(16'h0061, 3, SLOT, HALF);
        chk_res("R9", 1'b1, 16'h0061, 1'b0, 1'b1, 1'b0, 1'b0);

        // all-ones and alternating partner words
        do_reset(16'h01E1);
        send_n(16'hFFFF, 3, SLOT, HALF);
        chk_res("R4", 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1);
        do_reset(16'h01E1);
        send_n(16'hAAAA, 3, SLOT, HALF);
        chk_res("R4", 1'b1, 16'hAAAA, 1'b1, 1'b0, 1'b1, 1'b0);

        // differing word restarts the count; ack bit ignored in comparison
        do_reset(16'h01E1);
        send_n(16'h01E1, 2, SLOT, HALF);
        send_n(16'h0061, 1, SLOT, HALF);
        chk_res("R6", 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_n(16'h0061, 2, SLOT, HALF);
        chk_res("R6", 1'b1, 16'h0061, 1'b1, 1'b0, 1'b0, 1'b1);
        send_n(16'h4061, 1, SLOT, HALF);
        chk_res("R6", 1'b1, 16'h4061, 1'b1, 1'b0, 1'b0, 1'b1);
        // a different word withdraws acceptance and clears the result
        send_n(16'h0181, 1, SLOT, HALF);
        chk_res("R11", 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);

        // truncated burst is discarded without resetting the count
        do_reset(16'h01E1);
        send_n(16'h0121, 2, SLOT, HALF);
        send_burst(16'h0121, SLOT, HALF, 5);
        chk_res("R5", 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_n(16'h0121, 1, SLOT, HALF);
        chk_res("R5", 1'b1, 16'h0121, 1'b1, 1'b0, 1'b1, 1'b1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule